// File: doc/BRIEF.md
# Serial Management Frame Responder

This block is the device side of a two-wire serial management link. It uses the management clock as its only clock and samples the data line on each rising edge. It recognises a frame by a run of at least 32 ones, a two-bit start pattern and a two-bit operation code. It then checks a five-bit device address against a strap input. If all of these match, it reads or writes one 16-bit register through a plain parallel port that has an address, write data, a one-cycle write strobe and read data.

For a read, the block leaves the line released for the first turnaround bit. It drives a zero on the second turnaround bit and then shifts out the sixteen data bits, most significant first. It releases the line again after the last bit. A frame with a foreign address, an unknown operation code, a short preamble, a wrong start pattern or a wrong write turnaround is dropped without any register access and without driving the line. After any frame, complete or dropped, the decoder waits for a fresh preamble.

Top module: `mdio_resp`

## Requirements
- R1: While `rst_n` is low, `mdio_oe` and `reg_we` are 0 at once, even in the middle of a frame. After reset is released, a new preamble is needed before any frame is accepted.
- R2: A read frame (start 0,1; code 1,0; address equal to `phy_strap`) sets `reg_addr` to the 5-bit register field, sent MSB first, on the edge that samples its last bit. `mdio_oe` stays 0 during the first turnaround bit. The block drives `mdio_o` = 0 with `mdio_oe` = 1 for the second turnaround bit.
- R3: On a read, the 16 bits of `reg_rdata` are driven MSB first on the 16 bit periods after the turnaround. `mdio_oe` is then 0, so the line is driven for exactly 17 bit periods.
- R4: A write frame (code 0,1; turnaround 1,0) raises `reg_we` for exactly one cycle, right after the edge that samples D0. `reg_addr` and `reg_wdata` carry the register field and the data word. `mdio_oe` stays 0.
- R5: A frame whose device address differs from `phy_strap` causes no `reg_we` pulse and no driving of the line.
- R6: An operation code of 0,0 or 1,1 causes no access and no driving.
- R7: A preamble of fewer than 32 ones makes the following frame be ignored.
- R8: A start pattern other than 0,1 after a valid preamble makes the frame be ignored.
- R9: A write whose turnaround is not 1,0 causes no `reg_we` pulse.
- R10: A preamble longer than 32 ones is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_strap | input | 5 | Device address this responder answers to |
| mdio_i | input | 1 | Sampled level of the shared data line |
| mdio_o | output | 1 | Value driven onto the line when enabled |
| mdio_oe | output | 1 | Output enable of the line driver |
| reg_addr | output | 5 | Register address of the current access |
| reg_wdata | output | 16 | Write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Read data for `reg_addr`, combinational from the register file |

## Verification
Suppose the last register-address bit is sampled on edge k. Then `reg_addr` is valid after edge k, the line is still released just before edge k+1, and the zero turnaround bit is present just before edge k+2. Data bit D(15-j) can be seen just before edge k+3+j, and the line is released just before edge k+19. A write strobe is visible in the half cycle after the edge that samples D0, and it is gone one cycle later. The bench drives each bit on a falling clock edge and reads the outputs on the falling edge of exactly these cycles. After each frame it also compares the counts of strobe cycles and driven cycles against 1/0, 0/17 or 0/0.

// File: rtl/mdio_resp.sv
module mdio_resp #(
  parameter int DW      = 16,
  parameter int AW      = 5,
  parameter int PRE_LEN = 32
) (
  input  logic          mdc,
  input  logic          rst_n,
  input  logic [AW-1:0] phy_strap,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  localparam int PW = $clog2(PRE_LEN + 1);
  localparam int CW = $clog2((DW > 2 * AW) ? DW : 2 * AW);

  typedef enum logic [2:0] {S_PRE, S_ST, S_OP, S_ADR, S_TA, S_DAT} st_t;

  st_t           st;
  logic [PW-1:0] ones;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic          rd;

  wire              pre_ok = (ones == PW'(PRE_LEN));
  wire [2*AW-1:0]   adr    = {sh[2*AW-2:0], mdio_i};
  wire [DW-1:0]     sh_in  = {sh[DW-2:0], mdio_i};

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PRE;
      ones      <= '0;
      cnt       <= '0;
      sh        <= '0;
      rd        <= 1'b0;
      mdio_o    <= 1'b0;
      mdio_oe   <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      case (st)
        S_PRE: begin
          if (mdio_i) begin
            if (!pre_ok) ones <= ones + 1'b1;
          end else if (pre_ok) begin
            st <= S_ST;
          end else begin
            ones <= '0;
          end
        end
        S_ST: begin
          ones <= '0;
          cnt  <= '0;
          st   <= mdio_i ? S_OP : S_PRE;
        end
        S_OP: begin
          sh  <= sh_in;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(1)) begin
            cnt <= '0;
            if (sh[0] != mdio_i) begin
              rd <= sh[0];
              st <= S_ADR;
            end else begin
              st <= S_PRE;
            end
          end
        end
        S_ADR: begin
          sh  <= sh_in;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(2 * AW - 1)) begin
            cnt <= '0;
            if (adr[2*AW-1:AW] == phy_strap) begin
              reg_addr <= adr[AW-1:0];
              st       <= S_TA;
            end else begin
              st <= S_PRE;
            end
          end
        end
        S_TA: begin
          cnt <= cnt + 1'b1;
          if (cnt == '0) begin
            if (rd) begin
              mdio_oe <= 1'b1;
              mdio_o  <= 1'b0;
              sh      <= reg_rdata;
            end else if (!mdio_i) begin
              st <= S_PRE;
            end
          end else begin
            cnt <= '0;
            if (rd) begin
              mdio_o <= sh[DW-1];
              sh     <= sh << 1;
              st     <= S_DAT;
            end else begin
              st <= mdio_i ? S_PRE : S_DAT;
            end
          end
        end
        S_DAT: begin
          cnt <= cnt + 1'b1;
          if (rd) begin
            mdio_o <= sh[DW-1];
            sh     <= sh << 1;
          end else begin
            sh <= sh_in;
          end
          if (cnt == CW'(DW - 1)) begin
            cnt <= '0;
            st  <= S_PRE;
            if (rd) begin
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b0;
            end else begin
              reg_we    <= 1'b1;
              reg_wdata <= sh_in;
            end
          end
        end
        default: st <= S_PRE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_resp_chk.sv
module mdio_resp_chk #(
  parameter int DW = 16
) (
  input logic mdc,
  input logic rst_n,
  input logic mdio_o,
  input logic mdio_oe,
  input logic reg_we
);
  localparam int RW = $clog2(DW + 2) + 1;
  logic [RW-1:0] run;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n)       run <= '0;
    else if (mdio_oe) run <= run + 1'b1;
    else              run <= '0;
  end

  a_r4_we_one_cycle: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_we |=> !reg_we);

  a_r4_no_drive_on_write: assert property (@(posedge mdc) disable iff (!rst_n)
    !(reg_we && mdio_oe));

  a_r2_ta_zero: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  a_r3_drive_span: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(mdio_oe) |-> run == RW'(DW + 1));
endmodule

bind mdio_resp mdio_resp_chk #(.DW(DW)) u_chk (
  .mdc(mdc), .rst_n(rst_n), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_we(reg_we)
);

// File: tb/sim_mdio_resp.sv
`timescale 1ns/1ps
module sim_mdio_resp;
  localparam logic [4:0] STRAP = 5'h0B;

  typedef struct packed {
    logic [5:0]  pre;
    logic [1:0]  stf;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [1:0]  ta;
    logic [15:0] dat;
    logic [1:0]  kind;   // 0 ignored, 1 read, 2 write
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{6'd32, 2'b01, 2'b01, 5'h0B, 5'h03, 2'b10, 16'hA5C3, 2'd2, 4'd4},  // R4 write
    '{6'd32, 2'b01, 2'b10, 5'h0B, 5'h03, 2'b10, 16'h0000, 2'd1, 4'd3},  // R2 R3 read back
    '{6'd40, 2'b01, 2'b01, 5'h0B, 5'h1F, 2'b10, 16'hFFFF, 2'd2, 4'd10}, // R10 long preamble
    '{6'd32, 2'b01, 2'b10, 5'h0B, 5'h1F, 2'b10, 16'h0000, 2'd1, 4'd10}, // R10 read back
    '{6'd32, 2'b01, 2'b01, 5'h0C, 5'h05, 2'b10, 16'h1234, 2'd0, 4'd5},  // R5 foreign write
    '{6'd32, 2'b01, 2'b10, 5'h0C, 5'h05, 2'b10, 16'h0000, 2'd0, 4'd5},  // R5 foreign read
    '{6'd32, 2'b01, 2'b00, 5'h0B, 5'h05, 2'b10, 16'h5555, 2'd0, 4'd6},  // R6 code 00
    '{6'd32, 2'b01, 2'b11, 5'h0B, 5'h05, 2'b10, 16'h6666, 2'd0, 4'd6},  // R6 code 11
    '{6'd31, 2'b01, 2'b01, 5'h0B, 5'h05, 2'b10, 16'hBEEF, 2'd0, 4'd7},  // R7 short preamble
    '{6'd32, 2'b00, 2'b01, 5'h0B, 5'h05, 2'b10, 16'hBEEF, 2'd0, 4'd8},  // R8 bad start
    '{6'd32, 2'b01, 2'b01, 5'h0B, 5'h05, 2'b11, 16'hBEEF, 2'd0, 4'd9},  // R9 bad turnaround
    '{6'd32, 2'b01, 2'b10, 5'h0B, 5'h05, 2'b10, 16'h0000, 2'd1, 4'd5},  // R5..R9 reg 5 untouched
    '{6'd32, 2'b01, 2'b10, 5'h0B, 5'h00, 2'b10, 16'h0000, 2'd1, 4'd3}   // R3 other register
  };

  logic        mdc = 1'b0;
  logic        rst_n = 1'b0;
  logic        drv = 1'b1;
  logic        mdio_o, mdio_oe, reg_we;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] rf [32];
  logic [15:0] exp_mem [32];
  int          n_chk = 0, n_bad = 0, we_n = 0, oe_n = 0;

  wire        line  = mdio_oe ? mdio_o : drv;
  wire [15:0] rdata = rf[reg_addr];

  always #2.5 mdc = ~mdc;

  mdio_resp u0 (
    .mdc(mdc), .rst_n(rst_n), .phy_strap(STRAP), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(rdata)
  );

  function automatic logic [15:0] init_val(int i);
    return 16'h3C00 ^ 16'(i * 16'h0111);
  endfunction

  always @(posedge mdc) begin
    if (reg_we) begin
      rf[reg_addr] <= reg_wdata;
      we_n <= we_n + 1;
    end
    if (mdio_oe) oe_n <= oe_n + 1;
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    @(negedge mdc);
    drv = b;
  endtask

  task automatic header(input vec_t v);
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
    for (int i = 0; i < int'(v.pre); i++) bit_out(1'b1);
    bit_out(v.stf[1]); bit_out(v.stf[0]);
    bit_out(v.op[1]);  bit_out(v.op[0]);
    for (int i = 4; i >= 0; i--) bit_out(v.phy[i]);
    for (int i = 4; i >= 0; i--) bit_out(v.rg[i]);
  endtask

  task automatic run(input vec_t v);
    int we0, oe0;
    logic [15:0] got;
    string rq;
    rq = $sformatf("R%0d", v.req);
    we0 = we_n; oe0 = oe_n;
    header(v);
    if (v.kind == 2'd1) begin
      bit_out(1'b1);
      chk({rq, " R2 released on TA1"}, 16'(mdio_oe), 16'd0);
      chk({rq, " R2 reg_addr"}, 16'(reg_addr), 16'(v.rg));
      bit_out(1'b1);
      chk({rq, " R2 TA2 driven zero"}, {14'd0, mdio_oe, mdio_o}, 16'b10);
      got = '0;
      for (int j = 0; j < 16; j++) begin
        bit_out(1'b1);
        got[15-j] = mdio_o;
      end
      bit_out(1'b1);
      chk({rq, " R3 released after D0"}, 16'(mdio_oe), 16'd0);
      chk({rq, " R3 read data"}, got, exp_mem[v.rg]);
    end else begin
      bit_out(v.ta[1]); bit_out(v.ta[0]);
      for (int j = 15; j >= 0; j--) bit_out(v.dat[j]);
      bit_out(1'b1);
      if (v.kind == 2'd2) begin
        chk({rq, " R4 strobe high"}, 16'(reg_we), 16'd1);
        chk({rq, " R4 addr"}, 16'(reg_addr), 16'(v.rg));
        chk({rq, " R4 data"}, reg_wdata, v.dat);
        exp_mem[v.rg] = v.dat;
      end
      bit_out(1'b1);
      if (v.kind == 2'd2) chk({rq, " R4 strobe one cycle"}, 16'(reg_we), 16'd0);
    end
    bit_out(1'b1); bit_out(1'b1);
    chk({rq, " strobe count"}, 16'(we_n - we0), (v.kind == 2'd2) ? 16'd1 : 16'd0);
    chk({rq, " drive count"}, 16'(oe_n - oe0), (v.kind == 2'd1) ? 16'd17 : 16'd0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      rf[i] = init_val(i);
      exp_mem[i] = init_val(i);
    end
    repeat (3) @(negedge mdc);
    chk("R1 reset oe", 16'(mdio_oe), 16'd0);
    chk("R1 reset we", 16'(reg_we), 16'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) run(TBL[k]);

    // R1: reset in the middle of a read data phase releases the line at once
    header('{6'd32, 2'b01, 2'b10, STRAP, 5'h03, 2'b10, 16'h0, 2'd1, 4'd1});
    repeat (6) bit_out(1'b1);
    chk("R1 driving before reset", 16'(mdio_oe), 16'd1);
    #1 rst_n = 1'b0;
    #0.5 chk("R1 async release", 16'(mdio_oe), 16'd0);
    @(negedge mdc);
    rst_n = 1'b1;
    repeat (20) bit_out(1'b1);
    chk("R1 stays quiet after reset", 16'(mdio_oe), 16'd0);
    run(TBL[1]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired got %0d exp 0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule